// File: doc/BRIEF.md
# Root Hub Port Register Bank

This block holds one 32-bit status and control word for each downstream port of a USB host controller root hub, for up to four ports. The low half of each word shows the live condition of the port: whether a device is attached, whether the port is enabled, suspended, powered or held in reset, whether that device is low speed, and whether an overcurrent is present. The high half holds sticky change flags. Hardware sets these flags and software clears them by writing ones.

Software sends commands through a simple register write: power on or off, enable or disable, suspend or resume, and start a port reset. A built-in sequencer times the reset pulse against a 1 kHz tick taken from a parameterised clock divider. While the scheduler reports a bus transaction in flight, commands are held in a one-entry slot per port and take effect at the first clock edge after the transaction ends. Change-flag clears are not held back.

Top module: `rh_port_bank`

## Requirements
- R1: After a synchronous reset every bit of every implemented port word reads 0.
- R2: Bits 31:21, 15:10 and 7:5 always read 0, and writing them has no effect. A port index at or above NUM_PORTS reads all zero and ignores writes.
- R3: Bit 0 (connected) follows the attach input only while bit 8 (power) is set. Bit 9 (low speed) is set only while connected. Bit 16 sets whenever bit 0 changes.
- R4: Writing 1 to any of bits 20:16 clears that flag. Writing 0 leaves it unchanged.
- R5: If hardware sets a change flag in the same cycle that software clears it, the flag stays set.
- R6: Bit 3 follows the overcurrent input, and bit 19 sets on every change of bit 3. A rising overcurrent clears bit 1 (enabled), and bit 17 sets if the port was enabled.
- R7: Command bits in a write act as follows. Bit 0 disables the port. Bit 1 enables it if connected. Bit 2 suspends it if enabled. Bit 3 resumes a suspended port and sets bit 18. Bit 8 powers the port. Bit 9 removes power and clears enable and suspend. A clear beats a set.
- R8: Writing bit 4 to a connected port sets bit 4 (reset) for at least RESET_MS and at most RESET_MS+1 tick periods. In the cycle bit 4 falls, bit 20 and bit 1 both set.
- R9: A disconnect clears bit 1 and sets bit 17 if the port was enabled. A disconnect during a reset ends the reset without setting bit 20.
- R10: A command written while the transaction-busy input is high takes effect at the first clock edge at which busy is low. Until then it has no effect.
- R11: Only one command per port is held. A later command written during the same transaction replaces the earlier one.
- R12: Clears of change flags take effect at once, even while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Port index for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data: command bits and flag clears |
| reg_rdata | output | 32 | Word of the selected port |
| xact_busy | input | 1 | High while a bus transaction is in flight |
| line_attach | input | NUM_PORTS | Per-port device attach |
| line_lowspeed | input | NUM_PORTS | Per-port low-speed device indication |
| line_ovc | input | NUM_PORTS | Per-port overcurrent |

## Verification
The hardest conditions to reach are those where two things happen in the same cycle. One is a hardware flag set landing on a software clear. The other is a disconnect arriving in the middle of a timed reset. The bench drives the input change and the write strobe from the same falling edge so that both meet one rising edge. It drops the attach input a few dozen cycles into a running reset, then waits well past the reset window to show that the completion flag never sets. For deferral, the busy input is held across two writes to the same port, and the port word is read on the first edge after busy falls.

// File: rtl/rh_port_pkg.sv
// Shared constants for the root hub port register bank.
// Assumes at most four ports, so a two-bit port index.
package rh_port_pkg;
    localparam int SEL_W = 2;
    localparam int MAX_PORTS = 4;

    // Status bit positions of a port word
    localparam int B_CCS  = 0;
    localparam int B_PES  = 1;
    localparam int B_PSS  = 2;
    localparam int B_POCI = 3;
    localparam int B_PRS  = 4;
    localparam int B_PPS  = 8;
    localparam int B_LSDA = 9;
    // Change flag positions
    localparam int B_CSC  = 16;
    localparam int B_PESC = 17;
    localparam int B_PSSC = 18;
    localparam int B_OCIC = 19;
    localparam int B_PRSC = 20;

    // Command bits within the low ten bits of a write
    localparam int C_DIS   = 0;
    localparam int C_EN    = 1;
    localparam int C_SUSP  = 2;
    localparam int C_RES   = 3;
    localparam int C_RST   = 4;
    localparam int C_PON   = 8;
    localparam int C_POFF  = 9;
    localparam logic [9:0] CMD_MASK = 10'h31F;
endpackage

// File: rtl/rh_tick_div.sv
// Free-running clock divider producing a one-cycle tick every
// CLK_PER_TICK clocks (1 kHz in normal use). Assumes CLK_PER_TICK >= 2.
module rh_tick_div #(
    parameter int CLK_PER_TICK = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(CLK_PER_TICK);
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

    logic [CW-1:0] cnt;

    // Count clocks and pulse the tick on wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= (cnt == LAST);
            cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rh_rst_timer.sv
// Port reset sequencer. After start it stays busy until RESET_MS+1
// ticks have passed. This guarantees at least RESET_MS full periods.
// done_o pulses in the cycle whose edge drops busy. Abort stops the
// sequence without done.
module rh_rst_timer #(
    parameter int RESET_MS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic start_i,
    input  logic abort_i,
    output logic busy_o,
    output logic done_o
);
    localparam int TW = $clog2(RESET_MS + 1);
    localparam logic [TW-1:0] LAST = TW'(RESET_MS);

    logic [TW-1:0] cnt;

    // Completion is a combinational strobe on the final tick
    assign done_o = busy_o && tick_i && (cnt == LAST) && !abort_i;

    // Track reset interval progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt    <= '0;
        end else if (abort_i) begin
            busy_o <= 1'b0;
        end else if (start_i && !busy_o) begin
            busy_o <= 1'b1;
            cnt    <= '0;
        end else if (busy_o && tick_i) begin
            if (cnt == LAST) busy_o <= 1'b0;
            else             cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rh_port_slice.sv
// One port: live status, sticky change flags, a one-entry command slot
// held while a transaction is busy, and the reset sequencer.
// Assumes the line inputs are already synchronous to clk.
module rh_port_slice
    import rh_port_pkg::*;
#(
    parameter int RESET_MS = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        busy_i,
    input  logic        wr_i,
    input  logic [9:0]  cmd_i,
    input  logic [4:0]  clr_i,
    input  logic        attach_i,
    input  logic        lowspeed_i,
    input  logic        ovc_i,
    output logic [31:0] word_o
);
    logic ccs, pes, pss, poci, pps, lsda;
    logic csc, pesc, pssc, ocic, prsc;
    logic ccs_n, pes_n, pss_n, poci_n, pps_n, lsda_n;
    logic csc_n, pesc_n, pssc_n, ocic_n, prsc_n;
    logic prs, rst_done, rst_start, conn_fall, ovc_rise, resume;
    logic [9:0] cmd_in, pend_cmd, exec;
    logic       pend_v, has_cmd;
    logic [4:0] clr;

    assign cmd_in  = cmd_i & CMD_MASK;
    assign has_cmd = wr_i && (|cmd_in);
    assign clr     = wr_i ? clr_i : 5'b0;

    // Pick the command to apply this cycle: a fresh write wins over the slot
    always_comb begin
        exec = '0;
        if (!busy_i) begin
            if (has_cmd)     exec = cmd_in;
            else if (pend_v) exec = pend_cmd;
        end
    end

    // Hold one command while busy; a later write replaces it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v   <= 1'b0;
            pend_cmd <= '0;
        end else if (busy_i) begin
            if (has_cmd) begin
                pend_v   <= 1'b1;
                pend_cmd <= cmd_in;
            end
        end else begin
            pend_v <= 1'b0;
        end
    end

    // Next live status from commands and line inputs
    always_comb begin
        pps_n = pps;
        if (exec[C_PON])  pps_n = 1'b1;
        if (exec[C_POFF]) pps_n = 1'b0;

        ccs_n     = attach_i && pps;
        poci_n    = ovc_i;
        conn_fall = ccs && !ccs_n;
        ovc_rise  = !poci && poci_n;
        lsda_n    = lowspeed_i && ccs_n;

        pes_n = pes;
        if (exec[C_EN] && ccs) pes_n = 1'b1;
        if (rst_done)          pes_n = 1'b1;
        if (exec[C_DIS])       pes_n = 1'b0;
        if (conn_fall || ovc_rise || exec[C_POFF]) pes_n = 1'b0;

        resume = exec[C_RES] && pss;
        pss_n  = pss;
        if (exec[C_SUSP] && pes) pss_n = 1'b1;
        if (exec[C_RES])         pss_n = 1'b0;
        if (!pes_n)              pss_n = 1'b0;

        rst_start = exec[C_RST] && ccs && !conn_fall;
    end

    // Next change flags: hardware set outranks a same-cycle clear
    always_comb begin
        csc_n  = (csc  && !clr[0]) || (ccs != ccs_n);
        pesc_n = (pesc && !clr[1]) || (pes && (conn_fall || ovc_rise));
        pssc_n = (pssc && !clr[2]) || resume;
        ocic_n = (ocic && !clr[3]) || (poci != poci_n);
        prsc_n = (prsc && !clr[4]) || rst_done;
    end

    // Register status and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ccs, pes, pss, poci, pps, lsda}  <= '0;
            {csc, pesc, pssc, ocic, prsc}     <= '0;
        end else begin
            {ccs, pes, pss, poci, pps, lsda}  <= {ccs_n, pes_n, pss_n, poci_n, pps_n, lsda_n};
            {csc, pesc, pssc, ocic, prsc}     <= {csc_n, pesc_n, pssc_n, ocic_n, prsc_n};
        end
    end

    rh_rst_timer #(.RESET_MS(RESET_MS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .start_i (rst_start),
        .abort_i (conn_fall),
        .busy_o  (prs),
        .done_o  (rst_done)
    );

    assign word_o = {11'b0, prsc, ocic, pssc, pesc, csc,
                     6'b0, lsda, pps, 3'b0, prs, poci, pss, pes, ccs};
endmodule

// File: rtl/rh_port_bank.sv
// Top of the root hub port register bank: NUM_PORTS port slices, a
// shared 1 kHz tick and a read multiplexer. Assumes NUM_PORTS <= 4.
module rh_port_bank
    import rh_port_pkg::*;
#(
    parameter int NUM_PORTS    = 4,
    parameter int CLK_PER_TICK = 50000,
    parameter int RESET_MS     = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     reg_sel,
    input  logic                 reg_wr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 xact_busy,
    input  logic [NUM_PORTS-1:0] line_attach,
    input  logic [NUM_PORTS-1:0] line_lowspeed,
    input  logic [NUM_PORTS-1:0] line_ovc
);
    logic tick;
    logic [NUM_PORTS-1:0][31:0] port_word;
    logic unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:21], reg_wdata[15:10]};

    rh_tick_div #(.CLK_PER_TICK(CLK_PER_TICK)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rh_port_slice #(.RESET_MS(RESET_MS)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick),
            .busy_i     (xact_busy),
            .wr_i       (reg_wr && (reg_sel == SEL_W'(p))),
            .cmd_i      (reg_wdata[9:0]),
            .clr_i      (reg_wdata[20:16]),
            .attach_i   (line_attach[p]),
            .lowspeed_i (line_lowspeed[p]),
            .ovc_i      (line_ovc[p]),
            .word_o     (port_word[p])
        );
    end

    // Return the selected port word, zero for unimplemented indices
    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (reg_sel == SEL_W'(p)) reg_rdata = port_word[p];
        end
    end
endmodule

// File: rtl/rh_port_bank_chk.sv
// Property checker bound to rh_port_bank; watches every port word.
module rh_port_bank_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       xact_busy,
    input logic [NUM_PORTS-1:0][31:0] port_word
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        AST_CSC_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(port_word[p][0]) |-> port_word[p][16]); // R3
        AST_LSDA_NEEDS_CONN: assert property (@(posedge clk) disable iff (!rst_n)
            port_word[p][9] |-> port_word[p][0]); // R3
        AST_OCIC_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(port_word[p][3]) |-> port_word[p][19]); // R6
        AST_PRSC_AT_RESET_END: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_word[p][20]) |-> $fell(port_word[p][4])); // R8
        AST_POWER_HELD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            xact_busy |=> $stable(port_word[p][8])); // R10
    end
endmodule

bind rh_port_bank rh_port_bank_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xact_busy (xact_busy),
    .port_word (port_word)
);

// File: tb/rh_port_bank_test.sv
module rh_port_bank_test;
    localparam int NP  = 3;
    localparam int CPT = 20;
    localparam int RMS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xact_busy = 1'b0;
    logic [NP-1:0] line_attach = '0, line_lowspeed = '0, line_ovc = '0;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rh_port_bank #(.NUM_PORTS(NP), .CLK_PER_TICK(CPT), .RESET_MS(RMS)) uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xact_busy(xact_busy),
        .line_attach(line_attach), .line_lowspeed(line_lowspeed), .line_ovc(line_ovc));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; leaves the bench at the next falling edge
    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        reg_sel = sel; #1; v = reg_rdata;
    endtask

    task automatic t_reset_state;
        logic [31:0] v;
        for (int p = 0; p < 4; p++) begin
            rd(2'(p), v); chk("R1 reset value", v, 32'h0);
        end
    endtask

    task automatic t_power_connect;
        logic [31:0] v;
        wr(0, 32'h100);
        line_attach[0] = 1; line_lowspeed[0] = 1;
        @(negedge clk); rd(0, v); chk("R3 attach/lowspeed/csc", v, 32'h0001_0301);
        line_attach[1] = 1;
        repeat (2) @(negedge clk); rd(1, v); chk("R3 attach ignored unpowered", v, 32'h0);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(0, 32'h0); rd(0, v); chk("R4 write 0 keeps flag", v, 32'h0001_0301);
        wr(0, 32'h0001_0000); rd(0, v); chk("R4 write 1 clears flag", v, 32'h0301);
        wr(0, 32'hFFE0_FCE0); rd(0, v); chk("R2 reserved write no effect", v, 32'h0301);
        wr(3, 32'h100); rd(3, v); chk("R2 unimplemented port", v, 32'h0);
    endtask

    task automatic t_commands;
        logic [31:0] v;
        wr(0, 32'h2); rd(0, v); chk("R7 enable", v, 32'h0303);
        wr(0, 32'h4); rd(0, v); chk("R7 suspend", v, 32'h0307);
        wr(0, 32'h8); rd(0, v); chk("R7 resume sets flag", v, 32'h0004_0303);
        wr(0, 32'h0004_0000);
        wr(0, 32'h3); rd(0, v); chk("R7 disable beats enable", v, 32'h0301);
    endtask

    task automatic t_port_reset;
        logic [31:0] v;
        int n = 0;
        wr(0, 32'h10); rd(0, v); chk("R8 reset active", v, 32'h0311);
        while (n < 1000) begin
            @(negedge clk); n++; rd(0, v);
            if (v[20]) break;
        end
        chk("R8 reset width in window",
            32'((n >= RMS*CPT) && (n <= (RMS+1)*CPT + 2)), 32'h1);
        chk("R8 reset end word", v, 32'h0010_0303);
    endtask

    task automatic t_overcurrent;
        logic [31:0] v;
        line_ovc[0] = 1;
        @(negedge clk); rd(0, v); chk("R6 overcurrent", v, 32'h001A_0309);
        line_ovc[0] = 0;
        wr(0, 32'h0008_0000); rd(0, v); chk("R5 set beats clear", v, 32'h001A_0301);
        wr(0, 32'h000A_0000); rd(0, v); chk("R4 clear two flags", v, 32'h0010_0301);
    endtask

    task automatic t_defer;
        logic [31:0] v;
        xact_busy = 1;
        wr(2, 32'h100);
        repeat (3) @(negedge clk); rd(2, v); chk("R10 held while busy", v, 32'h0);
        wr(0, 32'h0010_0000); rd(0, v); chk("R12 clear while busy", v, 32'h0301);
        xact_busy = 0;
        @(negedge clk); rd(2, v); chk("R10 applied after busy", v, 32'h0100);
    endtask

    task automatic t_replace;
        logic [31:0] v;
        xact_busy = 1;
        wr(1, 32'h100); wr(1, 32'h2);
        xact_busy = 0;
        @(negedge clk); rd(1, v); chk("R11 later write replaced power", v, 32'h0);
        xact_busy = 1;
        wr(1, 32'h200); wr(1, 32'h100);
        xact_busy = 0;
        @(negedge clk); rd(1, v); chk("R11 replacement applied", v, 32'h0100);
    endtask

    task automatic t_abort;
        logic [31:0] v;
        line_attach[2] = 1;
        @(negedge clk); rd(2, v); chk("R3 port2 attach", v, 32'h0001_0101);
        wr(2, 32'h0001_0002); rd(2, v); chk("R7 port2 enabled", v, 32'h0103);
        wr(2, 32'h10);
        repeat (50) @(negedge clk); rd(2, v); chk("R8 port2 in reset", v, 32'h0113);
        line_attach[2] = 0;
        @(negedge clk); rd(2, v); chk("R9 disconnect aborts reset", v, 32'h0003_0100);
        repeat (300) @(negedge clk); rd(2, v); chk("R9 no completion flag", v, 32'h0003_0100);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_state();
        t_power_connect();
        t_w1c();
        t_commands();
        t_port_reset();
        t_overcurrent();
        t_defer();
        t_replace();
        t_abort();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule